// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out where an instruction operand lives in memory. It is given an addressing-mode code, the current program counter, the index register, the stack pointer and a bit-select value. It then reads the operand bytes that follow the opcode, one at a time, through a byte-wide read port. From those bytes it forms a 16-bit effective address, the bit-select to use, and the number of bytes by which the program counter must move on.

One calculation begins with a single-cycle start pulse while the block is idle. It ends with a single-cycle done pulse. In that done cycle the address, the bit-select and the PC advance are valid, or a fault is flagged instead.

Multi-byte operands arrive most significant byte first. A single fetched byte is zero-extended. Sums with the index register or stack pointer wrap modulo 2^16. A failed read ends the calculation at once with a fault.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (direct) reads one byte at PC. In the done cycle `ea_o` = {0x00, byte} and `adv_o` = 1.
- R2: Mode code 1 (extended) reads PC and then PC+1. It gives `ea_o` = {first byte, second byte} and `adv_o` = 2. `rd_addr_o` holds steady while a request waits for its response.
- R3: Mode code 2 (index, no offset) issues no read. It gives `ea_o` = index register, `adv_o` = 0, with done one cycle after start.
- R4: Mode code 3 (index + 8-bit offset) reads one byte at PC. It gives `ea_o` = (index + zero-extended byte) mod 2^16 and `adv_o` = 1.
- R5: Mode code 4 (index + 16-bit offset) reads two bytes, high first. It gives `ea_o` = (index + {b0,b1}) mod 2^16 with the carry dropped, and `adv_o` = 2.
- R6: Mode codes 5 and 6 behave like codes 3 and 4, with the stack pointer used in place of the index register.
- R7: Mode code 7 (direct bit) behaves like code 0 and also returns the start-time `bitsel_i` on `bit_o`. For every other mode, `bit_o` is 0.
- R8: A read answered with `rd_err_i` high ends the calculation. In the next cycle there is a done pulse with `fault_o` = 1, `ea_o` = 0, `adv_o` = 0 and `bit_o` = 0. No further read is issued.
- R9: The second operand byte is read at (PC+1) mod 2^16, so PC 0xFFFF reads 0xFFFF and then 0x0000.
- R10: Mode codes 8 to 15 give a done pulse with `fault_o` = 1 one cycle after start, and issue no read.
- R11: `done_o` lasts exactly one cycle. `busy_o` is high from the cycle after an accepted start through the done cycle. A start while busy is ignored, and the running calculation keeps its own inputs.
- R12: After reset, `busy_o`, `done_o`, `fault_o` and `rd_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a calculation (taken only while idle) |
| mode_i | input | 4 | Addressing-mode code |
| pc_i | input | 16 | Address of the first operand byte |
| ix_i | input | 16 | Index register |
| sp_i | input | 16 | Stack pointer |
| bitsel_i | input | 3 | Bit number for direct bit mode |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | Result is a fault (valid with done) |
| ea_o | output | 16 | Effective address (valid with done) |
| bit_o | output | 3 | Bit select (valid with done) |
| adv_o | output | 2 | PC advance in bytes (valid with done) |
| rd_req_o | output | 1 | Byte read request, held until answered |
| rd_addr_o | output | 16 | Byte read address |
| rd_valid_i | input | 1 | Read response strobe |
| rd_err_i | input | 1 | Response is a failure (valid with rd_valid_i) |
| rd_data_i | input | 8 | Read data (valid with rd_valid_i) |

## Verification
A corrupted byte counter or operand register shows up at the ports in one of three ways: a read at the wrong address, a missing or extra read, or a wrong `ea_o` in the very next done pulse. The bench therefore logs every address it answers and compares the result of each operation as soon as done rises. A latched mode or base that is lost or overwritten, for example by a start arriving while busy, shows up in the same done cycle as a wrong base, advance or bit value. Random response latency shifts the done cycle. This separates the errors that depend on response timing from those that depend only on the data.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int ADDR_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int MODE_W  = 4;
    localparam int BITSEL_W = 3;
    localparam int ADV_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        EM_DIR8  = 4'd0,
        EM_EXT16 = 4'd1,
        EM_IDX0  = 4'd2,
        EM_IDX8  = 4'd3,
        EM_IDX16 = 4'd4,
        EM_SPR8  = 4'd5,
        EM_SPR16 = 4'd6,
        EM_DBIT  = 4'd7
    } ea_mode_e;

    typedef enum logic [1:0] {
        BS_ZERO = 2'd0,
        BS_IX   = 2'd1,
        BS_SP   = 2'd2
    } base_sel_e;

    typedef struct packed {
        logic            legal;
        logic [ADV_W-1:0] nbytes;
        base_sel_e       base;
        logic            has_bit;
    } mode_info_t;

    function automatic mode_info_t decode_mode(input logic [MODE_W-1:0] code);
        mode_info_t r;
        r.legal   = 1'b1;
        r.nbytes  = '0;
        r.base    = BS_ZERO;
        r.has_bit = 1'b0;
        case (code)
            EM_DIR8:  r.nbytes = 2'd1;
            EM_EXT16: r.nbytes = 2'd2;
            EM_IDX0:  r.base = BS_IX;
            EM_IDX8:  begin r.nbytes = 2'd1; r.base = BS_IX; end
            EM_IDX16: begin r.nbytes = 2'd2; r.base = BS_IX; end
            EM_SPR8:  begin r.nbytes = 2'd1; r.base = BS_SP; end
            EM_SPR16: begin r.nbytes = 2'd2; r.base = BS_SP; end
            EM_DBIT:  begin r.nbytes = 2'd1; r.has_bit = 1'b1; end
            default:  r.legal = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
    import ea_pkg::*;
#(
    parameter int MW = MODE_W
) (
    input  logic [MW-1:0] mode_i,
    output mode_info_t    info_o
);
    always_comb begin
        info_o = decode_mode(MODE_W'(mode_i));
    end
endmodule

// File: rtl/ea_fetch_seq.sv
module ea_fetch_seq
    import ea_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  mode_info_t    info_i,
    input  logic [AW-1:0] pc_i,
    output logic          accept_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          fault_o,
    output logic [2*DW-1:0] opnd_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic          rd_err_i,
    input  logic [DW-1:0] rd_data_i
);
    localparam int OPW = 2 * DW;

    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DONE} seq_state_e;

    seq_state_e       state_q;
    logic             cnt_q;
    logic [ADV_W-1:0] need_q;
    logic [AW-1:0]    pc_q;
    logic [OPW-1:0]   opnd_q;
    logic             fault_q;
    logic             last_byte;

    assign accept_o  = start_i && (state_q == S_IDLE);
    assign last_byte = ({1'b0, cnt_q} + 2'd1) == need_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= 1'b0;
            need_q  <= '0;
            pc_q    <= '0;
            opnd_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        cnt_q   <= 1'b0;
                        need_q  <= info_i.nbytes;
                        pc_q    <= pc_i;
                        opnd_q  <= '0;
                        fault_q <= !info_i.legal;
                        if (!info_i.legal || info_i.nbytes == '0)
                            state_q <= S_DONE;
                        else
                            state_q <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (rd_valid_i) begin
                        if (rd_err_i) begin
                            fault_q <= 1'b1;
                            state_q <= S_DONE;
                        end else begin
                            opnd_q <= {opnd_q[DW-1:0], rd_data_i};
                            if (last_byte)
                                state_q <= S_DONE;
                            else
                                cnt_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy_o    = state_q != S_IDLE;
    assign done_o    = state_q == S_DONE;
    assign fault_o   = done_o && fault_q;
    assign opnd_o    = opnd_q;
    assign rd_req_o  = state_q == S_FETCH;
    assign rd_addr_o = pc_q + AW'(cnt_q);
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W,
    parameter int BW = BITSEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  mode_info_t    info_i,
    input  logic [AW-1:0] ix_i,
    input  logic [AW-1:0] sp_i,
    input  logic [BW-1:0] bitsel_i,
    input  logic          done_i,
    input  logic          fault_i,
    input  logic [2*DW-1:0] opnd_i,
    output logic [AW-1:0] ea_o,
    output logic [BW-1:0] bit_o,
    output logic [ADV_W-1:0] adv_o
);
    mode_info_t    info_q;
    logic [AW-1:0] ix_q;
    logic [AW-1:0] sp_q;
    logic [BW-1:0] bit_q;
    logic [AW-1:0] base;
    logic [AW-1:0] sum;
    logic          good;

    always_ff @(posedge clk) begin
        if (rst) begin
            info_q <= '0;
            ix_q   <= '0;
            sp_q   <= '0;
            bit_q  <= '0;
        end else if (load_i) begin
            info_q <= info_i;
            ix_q   <= ix_i;
            sp_q   <= sp_i;
            bit_q  <= bitsel_i;
        end
    end

    always_comb begin
        case (info_q.base)
            BS_IX:   base = ix_q;
            BS_SP:   base = sp_q;
            default: base = '0;
        endcase
        sum  = base + AW'(opnd_i);
        good = done_i && !fault_i;
        ea_o  = good ? sum : '0;
        adv_o = good ? info_q.nbytes : '0;
        bit_o = (good && info_q.has_bit) ? bit_q : '0;
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W,
    parameter int MW = MODE_W,
    parameter int BW = BITSEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [MW-1:0] mode_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] ix_i,
    input  logic [AW-1:0] sp_i,
    input  logic [BW-1:0] bitsel_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          fault_o,
    output logic [AW-1:0] ea_o,
    output logic [BW-1:0] bit_o,
    output logic [ADV_W-1:0] adv_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic          rd_err_i,
    input  logic [DW-1:0] rd_data_i
);
    mode_info_t       info;
    logic             accept;
    logic [2*DW-1:0]  opnd;

    ea_mode_dec #(.MW(MW)) u_dec (
        .mode_i (mode_i),
        .info_o (info)
    );

    ea_fetch_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .info_i     (info),
        .pc_i       (pc_i),
        .accept_o   (accept),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .fault_o    (fault_o),
        .opnd_o     (opnd),
        .rd_req_o   (rd_req_o),
        .rd_addr_o  (rd_addr_o),
        .rd_valid_i (rd_valid_i),
        .rd_err_i   (rd_err_i),
        .rd_data_i  (rd_data_i)
    );

    ea_addr_calc #(.AW(AW), .DW(DW), .BW(BW)) u_calc (
        .clk      (clk),
        .rst      (rst),
        .load_i   (accept),
        .info_i   (info),
        .ix_i     (ix_i),
        .sp_i     (sp_i),
        .bitsel_i (bitsel_i),
        .done_i   (done_o),
        .fault_i  (fault_o),
        .opnd_i   (opnd),
        .ea_o     (ea_o),
        .bit_o    (bit_o),
        .adv_o    (adv_o)
    );
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int AW = 16,
    parameter int MW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic [MW-1:0] mode_i,
    input logic [AW-1:0] ix_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          fault_o,
    input logic [AW-1:0] ea_o,
    input logic [1:0]    adv_o,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_valid_i
);
    // R11: requests only while a calculation runs
    p_req_in_busy_r11: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> busy_o);

    // R11: done is a single-cycle strobe
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: a fault carries no address and no advance
    p_fault_noaddr_r8: assert property (@(posedge clk) disable iff (rst)
        (done_o && fault_o) |-> (ea_o == '0 && adv_o == 2'd0));

    // R10: undefined codes fault in the next cycle
    p_illegal_fault_r10: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && mode_i[MW-1]) |=> (done_o && fault_o && !rd_req_o));

    // R3: plain index mode finishes next cycle with the index value
    p_idx0_r3: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && mode_i == MW'(2)) |=>
            (done_o && !fault_o && !rd_req_o && ea_o == $past(ix_i)));

    // R2: an unanswered request keeps its address
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .MW(MW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .ix_i       (ix_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fault_o    (fault_o),
    .ea_o       (ea_o),
    .adv_o      (adv_o),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_valid_i (rd_valid_i)
);

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [15:0] pc_i = '0, ix_i = '0, sp_i = '0;
    logic [2:0]  bitsel_i = '0;
    logic        busy_o, done_o, fault_o, rd_req_o;
    logic [15:0] ea_o, rd_addr_o;
    logic [2:0]  bit_o;
    logic [1:0]  adv_o;
    logic        rd_valid_i = 1'b0, rd_err_i = 1'b0;
    logic [7:0]  rd_data_i = '0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic        err_en = 1'b0;
    logic [15:0] err_addr = '0;
    int          nrd = 0;
    logic [15:0] rlog [2];
    int          wcnt = 0;

    always #4 clk = ~clk;

    ea_gen u0 (.*);

    function automatic logic [7:0] memb(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    function automatic int nbytes_of(input logic [3:0] m);
        case (m)
            4'd0, 4'd3, 4'd5, 4'd7: return 1;
            4'd1, 4'd4, 4'd6:       return 2;
            default:                return 0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5, 4'd6: return "R6";
            4'd7: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // memory model: answers each request after 0..2 wait cycles
    always @(negedge clk) begin
        rd_valid_i = 1'b0;
        rd_err_i   = 1'b0;
        if (rd_req_o) begin
            if (wcnt == 0) begin
                rd_valid_i = 1'b1;
                rd_data_i  = memb(rd_addr_o);
                rd_err_i   = err_en && (rd_addr_o == err_addr);
                if (nrd < 2) rlog[nrd] = rd_addr_o;
                nrd++;
                wcnt = int'($urandom % 3);
            end else begin
                wcnt--;
            end
        end
    end

    task automatic run_op(input logic [3:0] m, input logic [15:0] pc, input logic [15:0] ix,
                          input logic [15:0] sp, input logic [2:0] bs,
                          input bit een, input logic [15:0] eaddr, input bit poke);
        int nb, exp_rd, waited;
        logic [7:0] b0, b1;
        logic [15:0] p1, opnd, base, exp_ea;
        bit exp_fault;
        logic [1:0] exp_adv;
        logic [2:0] exp_bit;
        string tg;
        tg = tag_of(m);
        nb = nbytes_of(m);
        p1 = pc + 16'd1;
        b0 = memb(pc);
        b1 = memb(p1);
        exp_fault = (m >= 4'd8);
        exp_rd = nb;
        if (een && eaddr == pc && nb > 0) begin exp_fault = 1; exp_rd = 1; end
        else if (een && eaddr == p1 && nb == 2) exp_fault = 1;
        if (exp_fault) tg = (m >= 4'd8) ? "R10" : "R8";
        opnd = (nb == 2) ? {b0, b1} : (nb == 1) ? {8'h00, b0} : 16'h0000;
        base = (m == 4'd2 || m == 4'd3 || m == 4'd4) ? ix :
               (m == 4'd5 || m == 4'd6) ? sp : 16'h0000;
        exp_ea  = exp_fault ? 16'h0 : base + opnd;
        exp_adv = exp_fault ? 2'd0 : 2'(nb);
        exp_bit = (!exp_fault && m == 4'd7) ? bs : 3'd0;

        @(negedge clk);
        err_en = een; err_addr = eaddr; nrd = 0;
        start_i = 1'b1; mode_i = m; pc_i = pc; ix_i = ix; sp_i = sp; bitsel_i = bs;
        @(negedge clk);
        start_i = 1'b0;
        if (poke && busy_o && !done_o) begin
            // R11: start while busy must be ignored
            start_i = 1'b1; mode_i = 4'd2; ix_i = ~ix; sp_i = ~sp; bitsel_i = ~bs; pc_i = ~pc;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        chk(done_o, tg, "done seen", 32'(done_o), 32'd1);
        chk(fault_o == exp_fault, tg, "fault", 32'(fault_o), 32'(exp_fault));
        chk(ea_o == exp_ea, tg, "ea", 32'(ea_o), 32'(exp_ea));
        chk(adv_o == exp_adv, tg, "adv", 32'(adv_o), 32'(exp_adv));
        chk(bit_o == exp_bit, (m == 4'd7) ? "R7" : tg, "bit", 32'(bit_o), 32'(exp_bit));
        chk(nrd == exp_rd, tg, "read count", 32'(nrd), 32'(exp_rd));
        if (nrd >= 1 && exp_rd >= 1)
            chk(rlog[0] == pc, "R2", "first read addr", 32'(rlog[0]), 32'(pc));
        if (nrd >= 2 && exp_rd >= 2)
            chk(rlog[1] == p1, (pc == 16'hFFFF) ? "R9" : "R2", "second read addr",
                32'(rlog[1]), 32'(p1));
        @(negedge clk);
        chk(!done_o, "R11", "done single pulse", 32'(done_o), 32'd0);
        if (poke)
            chk(!busy_o, "R11", "no second op after poke", 32'(busy_o), 32'd0);
        err_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk(!busy_o && !done_o && !fault_o && !rd_req_o, "R12", "reset outputs",
            {28'd0, busy_o, done_o, fault_o, rd_req_o}, 32'd0);

        // directed cases
        run_op(4'd0, 16'h1234, 16'h0, 16'h0, 3'd0, 0, 16'h0, 0);      // R1
        run_op(4'd1, 16'h2000, 16'h0, 16'h0, 3'd0, 0, 16'h0, 0);      // R2
        run_op(4'd2, 16'h3000, 16'hBEEF, 16'h0, 3'd0, 0, 16'h0, 0);   // R3
        run_op(4'd3, 16'h4010, 16'hFFF0, 16'h0, 3'd0, 0, 16'h0, 0);   // R4 carry dropped
        run_op(4'd4, 16'h5000, 16'hFF00, 16'h0, 3'd0, 0, 16'h0, 0);   // R5
        run_op(4'd5, 16'h6000, 16'h0, 16'hFFFE, 3'd0, 0, 16'h0, 0);   // R6
        run_op(4'd6, 16'h7000, 16'h0, 16'h8000, 3'd0, 0, 16'h0, 0);   // R6
        run_op(4'd7, 16'h0080, 16'h0, 16'h0, 3'd5, 0, 16'h0, 0);      // R7
        run_op(4'd1, 16'hFFFF, 16'h0, 16'h0, 3'd0, 0, 16'h0, 0);      // R9
        run_op(4'd4, 16'hFFFF, 16'h1111, 16'h0, 3'd0, 0, 16'h0, 0);   // R9
        run_op(4'd1, 16'h0100, 16'h0, 16'h0, 3'd0, 1, 16'h0100, 0);   // R8 first byte
        run_op(4'd6, 16'h0200, 16'h0, 16'h1, 3'd0, 1, 16'h0201, 0);   // R8 second byte
        run_op(4'd9, 16'h0300, 16'h0, 16'h0, 3'd0, 0, 16'h0, 0);      // R10
        run_op(4'd15, 16'h0400, 16'h0, 16'h0, 3'd0, 0, 16'h0, 0);     // R10
        run_op(4'd1, 16'h0500, 16'h0, 16'h0, 3'd0, 0, 16'h0, 1);      // R11 poke
        run_op(4'd5, 16'h0600, 16'h0, 16'h4444, 3'd0, 0, 16'h0, 1);   // R11 poke

        // random mix
        for (int i = 0; i < 120; i++) begin
            logic [3:0]  m;
            logic [15:0] pc;
            bit een;
            m  = 4'($urandom % 16);
            pc = ($urandom % 8 == 0) ? 16'hFFFF : 16'($urandom);
            een = ($urandom % 6 == 0);
            run_op(m, pc, 16'($urandom), 16'($urandom), 3'($urandom),
                   een, ($urandom % 2 == 0) ? pc : pc + 16'd1, ($urandom % 5 == 0));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule